// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight edge-triggered interrupt request lines, ranks them by a fixed priority (line 0 first, line 7 last), and tells the processor through a single interrupt output when a request is pending that outranks everything currently being serviced. Software talks to it through a byte-wide register port with one address bit. A command-word sequence sets the vector base and the cascade wiring. After that, the same port gives access to the mask, to end-of-interrupt and read-select commands, to a poll command, and to readback of the pending-request and in-service registers.

The processor acknowledges an interrupt in one of two ways. It can issue two acknowledge pulses, and the second pulse returns an 8-bit vector made of the programmed base and the 3-bit level. Or it can arm a poll and then read the port, and that read does the acknowledge. Two instances can be cascaded. A master marks which of its inputs carry a secondary controller and, during an acknowledge of such an input, drives the 3-bit level on the cascade lines. A secondary controller holds its own identity and answers only when the cascade lines carry that identity. When a request has gone away before it is acknowledged, the controller reports level 7 and leaves the in-service register unchanged, so software can detect the spurious case.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask reads 0xFF, reads at address bit 0 return the pending-request register (0x00), the interrupt output is low, the vector base is 0 and no cascade input is marked.
- R2: A write at address bit 0 with data bit 4 set starts initialization. It clears the in-service and pending registers and restores pending-register readback, and it leaves the mask unchanged. The following address-1 writes are taken in this order: the base word (bits 7:3 become vector bits 7:3); the cascade word, which is skipped when bit 1 of the start word is set; and the mode word, which is taken only when bit 0 of the start word is set. Address-1 writes after that load the mask.
- R3: Outside initialization, an address-1 write loads the mask (1 masks a level) and an address-1 read returns it. A masked level never raises the interrupt output and is never chosen by a poll.
- R4: A rising edge on an input latches its pending bit. The bit clears when the input goes low or when the level is acknowledged. An input held high after acknowledge does not request again.
- R5: The interrupt output is high exactly when the lowest-numbered unmasked pending level is numerically lower than every in-service level.
- R6: A write of 0x20 at address 0 (bits 7:5 = 001, bits 4:3 = 00) clears the lowest-numbered set in-service bit only.
- R7: A write at address 0 with bit 4 = 0, bit 3 = 1 and bit 1 = 1 selects in-service readback when bit 0 = 1 (0x0B) and pending readback when bit 0 = 0 (0x0A). The selection persists across reads at address 0.
- R8: A write at address 0 with bit 4 = 0, bit 3 = 1 and bit 2 = 1 (0x0C) arms a poll. The next address-0 read returns 0x80 | level and acknowledges that level. Later reads return the selected register again.
- R9: On the first of two acknowledge pulses the winning level's in-service bit is set and its pending bit cleared. During the second pulse the vector output carries {base[7:3], level[2:0]} with its valid flag high for that cycle.
- R10: When no level qualifies at the moment of acknowledge, the controller reports level 7 (vector base | 7, or poll byte 0x07 with bit 7 clear) and leaves the in-service register unchanged.
- R11: A master with cascade-word bit n set, acknowledging level n, drives the cascade lines with n and their enable high on both pulses, and does not drive the vector.
- R12: A secondary controller (master select low) takes its identity from cascade-word bits 2:0. It acknowledges and drives its vector only when the cascade enable is high and the cascade lines equal that identity; otherwise its state is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irq_in | input | 8 | Interrupt request lines, level 0 highest |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge pulse, one cycle per pulse |
| vec_o | output | 8 | Vector during the second acknowledge pulse |
| vec_vld_o | output | 1 | Vector output is driven |
| is_master_i | input | 1 | 1 = master, 0 = secondary |
| cas_i | input | 3 | Cascade level seen by a secondary |
| cas_en_i | input | 1 | Cascade lines are driven |
| cas_o | output | 3 | Cascade level driven by a master |
| cas_en_o | output | 1 | Master is driving the cascade lines |

## Verification
Each level is raised alone and then polled, acknowledged and ended, which shows that the encoding, ISR set/clear and interrupt blocking work level by level. Every pair of levels is raised together, which separates fixed-priority order from nesting behaviour. All 256 mask values are tried with every input raised, so any off-by-one in the masked lowest-index search shows up. Directed runs cover a request that drops before acknowledge, in-service nesting with end-of-interrupt, single-mode initialization with a relocated base, and a master/secondary pair in which the cascade lines either select the secondary or leave it untouched.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int BYTE_W  = 8;
    localparam int BASE_W  = BYTE_W - LVL_W;

    typedef enum logic [1:0] {
        CFG_RUN,
        CFG_BASE,
        CFG_CASC,
        CFG_MODE
    } cfg_st_e;

    typedef struct packed {
        cfg_st_e             st;
        logic                single;
        logic                want_mode;
        logic [BASE_W-1:0]   base;
        logic [BYTE_W-1:0]   casc;
        logic [BYTE_W-1:0]   mask;
        logic                sel_isr;
        logic                poll_arm;
    } cfg_t;

    typedef struct packed {
        logic [NUM_LVL-1:0]  isr;
        logic                phase;
        logic [LVL_W-1:0]    lvl;
        logic                drive;
        logic                owned;
    } ack_t;

endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
    import prio_intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                a0,
    input  logic [BYTE_W-1:0]   wdata,
    output logic                init_clr_o,
    output logic                eoi_o,
    output logic                poll_rd_o,
    output logic                poll_arm_o,
    output logic                sel_isr_o,
    output logic [BASE_W-1:0]   base_o,
    output logic [BYTE_W-1:0]   casc_o,
    output logic [BYTE_W-1:0]   mask_o
);

    cfg_t cfg_d, cfg_q;
    logic init_clr_d, eoi_d, poll_rd_d;

    always_comb begin
        cfg_d      = cfg_q;
        init_clr_d = 1'b0;
        eoi_d      = 1'b0;
        poll_rd_d  = 1'b0;
        if (wr_en) begin
            if (!a0 && wdata[4]) begin
                // start of the command-word sequence
                cfg_d.st        = CFG_BASE;
                cfg_d.single    = wdata[1];
                cfg_d.want_mode = wdata[0];
                cfg_d.casc      = '0;
                cfg_d.sel_isr   = 1'b0;
                cfg_d.poll_arm  = 1'b0;
                init_clr_d      = 1'b1;
            end else if (a0) begin
                unique case (cfg_q.st)
                    CFG_BASE: begin
                        cfg_d.base = wdata[BYTE_W-1:LVL_W];
                        if (!cfg_q.single)       cfg_d.st = CFG_CASC;
                        else if (cfg_q.want_mode) cfg_d.st = CFG_MODE;
                        else                      cfg_d.st = CFG_RUN;
                    end
                    CFG_CASC: begin
                        cfg_d.casc = wdata;
                        cfg_d.st   = cfg_q.want_mode ? CFG_MODE : CFG_RUN;
                    end
                    CFG_MODE: begin
                        cfg_d.st = CFG_RUN;
                    end
                    default: begin
                        cfg_d.mask = wdata;
                    end
                endcase
            end else if (cfg_q.st == CFG_RUN) begin
                if (wdata[3]) begin
                    if (wdata[2]) cfg_d.poll_arm = 1'b1;
                    if (wdata[1]) cfg_d.sel_isr  = wdata[0];
                end else if (wdata[7:5] == 3'b001) begin
                    eoi_d = 1'b1;
                end
            end
        end else if (rd_en && !a0 && cfg_q.poll_arm) begin
            poll_rd_d      = 1'b1;
            cfg_d.poll_arm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.st        <= CFG_RUN;
            cfg_q.single    <= 1'b0;
            cfg_q.want_mode <= 1'b0;
            cfg_q.base      <= '0;
            cfg_q.casc      <= '0;
            cfg_q.mask      <= '1;
            cfg_q.sel_isr   <= 1'b0;
            cfg_q.poll_arm  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign init_clr_o = init_clr_d;
    assign eoi_o      = eoi_d;
    assign poll_rd_o  = poll_rd_d;
    assign poll_arm_o = cfg_q.poll_arm;
    assign sel_isr_o  = cfg_q.sel_isr;
    assign base_o     = cfg_q.base;
    assign casc_o     = cfg_q.casc;
    assign mask_o     = cfg_q.mask;

    AST_MASK_FROZEN_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.st != CFG_RUN) |=> (cfg_q.mask == $past(cfg_q.mask))); // R2

    AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        poll_rd_o |=> !cfg_q.poll_arm); // R8

endmodule

// File: rtl/prio_intc_irr.sv
module prio_intc_irr #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    input  logic         flush_i,
    output logic [N-1:0] irr_o
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] irr;
    } irr_st_t;

    irr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = req_i;
        if (flush_i) begin
            st_d.irr = '0;
        end else begin
            // latch on a rising edge, hold only while the line stays high
            st_d.irr = (st_q.irr | (req_i & ~st_q.prev)) & req_i & ~clr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irr_o = st_q.irr;

    AST_IRR_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.irr & ~$past(st_q.irr)) & ~$past(req_i & ~st_q.prev)) == '0); // R4

endmodule

// File: rtl/prio_intc_resolve.sv
module prio_intc_resolve #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  isr_i,
    output logic [LW-1:0] win_lvl_o,
    output logic          win_ok_o,
    output logic [LW-1:0] svc_lvl_o,
    output logic          svc_any_o
);

    logic [N-1:0]  pend;
    logic [LW-1:0] p_lvl;
    logic          p_any;

    assign pend = irr_i & ~mask_i;

    always_comb begin
        p_lvl     = '0;
        p_any     = 1'b0;
        svc_lvl_o = '0;
        svc_any_o = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (pend[k]) begin
                p_lvl = LW'(k);
                p_any = 1'b1;
            end
            if (isr_i[k]) begin
                svc_lvl_o = LW'(k);
                svc_any_o = 1'b1;
            end
        end
    end

    assign win_lvl_o = p_lvl;
    assign win_ok_o  = p_any && (!svc_any_o || (p_lvl < svc_lvl_o));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic         a0,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [7:0]   irq_in,
    output logic         int_o,
    input  logic         inta_i,
    output logic [7:0]   vec_o,
    output logic         vec_vld_o,
    input  logic         is_master_i,
    input  logic [2:0]   cas_i,
    input  logic         cas_en_i,
    output logic [2:0]   cas_o,
    output logic         cas_en_o
);

    logic                init_clr, eoi, poll_rd, poll_arm, sel_isr;
    logic [BASE_W-1:0]   base;
    logic [BYTE_W-1:0]   casc, mask;
    logic [NUM_LVL-1:0]  irr, irr_clr;
    logic [LVL_W-1:0]    win_lvl, svc_lvl;
    logic                win_ok, svc_any;

    ack_t ack_d, ack_q;

    logic [NUM_LVL-1:0]  isr_set, isr_clr;
    logic                first_pulse, take_part, slv_own;
    logic [LVL_W-1:0]    rep_lvl;
    logic [BYTE_W-1:0]   poll_byte;

    prio_intc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .a0         (a0),
        .wdata      (wdata),
        .init_clr_o (init_clr),
        .eoi_o      (eoi),
        .poll_rd_o  (poll_rd),
        .poll_arm_o (poll_arm),
        .sel_isr_o  (sel_isr),
        .base_o     (base),
        .casc_o     (casc),
        .mask_o     (mask)
    );

    prio_intc_irr #(.N(NUM_LVL)) u_irr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (irq_in),
        .clr_i   (irr_clr),
        .flush_i (init_clr),
        .irr_o   (irr)
    );

    prio_intc_resolve #(.N(NUM_LVL), .LW(LVL_W)) u_resolve (
        .irr_i     (irr),
        .mask_i    (mask),
        .isr_i     (ack_q.isr),
        .win_lvl_o (win_lvl),
        .win_ok_o  (win_ok),
        .svc_lvl_o (svc_lvl),
        .svc_any_o (svc_any)
    );

    assign first_pulse = inta_i && !ack_q.phase;
    assign take_part   = is_master_i || (cas_en_i && (cas_i == casc[LVL_W-1:0]));
    assign slv_own     = is_master_i && win_ok && casc[win_lvl];
    assign rep_lvl     = win_ok ? win_lvl : LVL_W'(NUM_LVL - 1);

    always_comb begin
        ack_d   = ack_q;
        isr_set = '0;
        isr_clr = '0;
        if (first_pulse) begin
            ack_d.phase = 1'b1;
            ack_d.lvl   = rep_lvl;
            ack_d.drive = take_part && !slv_own;
            ack_d.owned = take_part && slv_own;
            if (take_part && win_ok) isr_set[win_lvl] = 1'b1;
        end else if (inta_i) begin
            ack_d.phase = 1'b0;
        end else if (poll_rd && win_ok) begin
            isr_set[win_lvl] = 1'b1;
        end
        if (eoi && svc_any) isr_clr[svc_lvl] = 1'b1;
        ack_d.isr = (ack_q.isr | isr_set) & ~isr_clr;
        if (init_clr) begin
            ack_d.isr   = '0;
            ack_d.phase = 1'b0;
            ack_d.drive = 1'b0;
            ack_d.owned = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else begin
            ack_q <= ack_d;
        end
    end

    assign irr_clr   = isr_set;
    assign int_o     = win_ok;
    assign vec_vld_o = inta_i && ack_q.phase && ack_q.drive;
    assign vec_o     = vec_vld_o ? {base, ack_q.lvl} : '0;
    assign cas_en_o  = is_master_i &&
                       ((first_pulse && slv_own) || (ack_q.phase && ack_q.owned));
    assign cas_o     = !cas_en_o ? '0 : (ack_q.phase ? ack_q.lvl : win_lvl);
    assign poll_byte = win_ok ? {1'b1, 4'b0000, win_lvl} : 8'h07;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (a0)           rdata = mask;
            else if (poll_arm) rdata = poll_byte;
            else if (sel_isr)  rdata = ack_q.isr;
            else               rdata = irr;
        end
    end

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pulse && take_part && win_ok && !init_clr) |=> ack_q.isr[$past(win_lvl)]); // R9

    AST_SPURIOUS_KEEPS_ISR7: assert property (@(posedge clk) disable iff (!rst_n)
        (first_pulse && !win_ok && !eoi && !init_clr) |=> (ack_q.isr[NUM_LVL-1] == $past(ack_q.isr[NUM_LVL-1]))); // R10

    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (ack_q.isr != '0) && !inta_i && !poll_rd && !init_clr)
        |=> ($countones(ack_q.isr) == $past($countones(ack_q.isr)) - 1)); // R6

    AST_CAS_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        cas_en_o |-> is_master_i); // R11

    AST_VEC_CARRIES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (vec_o[BYTE_W-1:LVL_W] == base)); // R9

    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((irr & ~mask) != '0)); // R3

endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
    logic       a0 = 0;
    logic [7:0] wdata = 0;
    logic [7:0] m_rdata, s_rdata;
    logic [7:0] m_irq = 0, s_irq = 0;
    logic       m_int, s_int;
    logic       inta = 0;
    logic [7:0] m_vec, s_vec;
    logic       m_vld, s_vld;
    logic [2:0] m_cas, s_cas_unused;
    logic       m_casen, s_casen_unused;
    logic [7:0] m_irq_all;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign m_irq_all = {m_irq[7:3], m_irq[2] | s_int, m_irq[1:0]};

    prio_intc u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(m_wr), .rd_en(m_rd), .a0(a0),
        .wdata(wdata), .rdata(m_rdata), .irq_in(m_irq_all), .int_o(m_int),
        .inta_i(inta), .vec_o(m_vec), .vec_vld_o(m_vld), .is_master_i(1'b1),
        .cas_i(3'd0), .cas_en_i(1'b0), .cas_o(m_cas), .cas_en_o(m_casen)
    );

    prio_intc u_slv (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .rd_en(s_rd), .a0(a0),
        .wdata(wdata), .rdata(s_rdata), .irq_in(s_irq), .int_o(s_int),
        .inta_i(inta), .vec_o(s_vec), .vec_vld_o(s_vld), .is_master_i(1'b0),
        .cas_i(m_cas), .cas_en_i(m_casen), .cas_o(s_cas_unused), .cas_en_o(s_casen_unused)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit tgt, input bit a, input logic [7:0] d);
        @(negedge clk);
        a0 = a; wdata = d;
        if (tgt) s_wr = 1; else m_wr = 1;
        @(posedge clk); #1;
        m_wr = 0; s_wr = 0;
    endtask

    task automatic rd(input bit tgt, input bit a, output logic [7:0] d);
        @(negedge clk);
        a0 = a;
        if (tgt) s_rd = 1; else m_rd = 1;
        #1 d = tgt ? s_rdata : m_rdata;
        @(posedge clk); #1;
        m_rd = 0; s_rd = 0;
    endtask

    // one acknowledge pulse; captures both chips' outputs mid-pulse
    logic [7:0] p_mvec, p_svec;
    logic       p_mvld, p_svld, p_casen;
    logic [2:0] p_cas;
    task automatic pulse();
        @(negedge clk);
        inta = 1;
        #1;
        p_mvec = m_vec; p_mvld = m_vld; p_svec = s_vec; p_svld = s_vld;
        p_cas = m_cas; p_casen = m_casen;
        @(posedge clk); #1;
        inta = 0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        m_irq = v;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic init_std(input bit tgt, input logic [7:0] base, input logic [7:0] cw);
        wr(tgt, 0, 8'h11);
        wr(tgt, 1, base);
        wr(tgt, 1, cw);
        wr(tgt, 1, 8'h01);
        wr(tgt, 1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, exp;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(0, 1, d); check("R1 mask", d, 8'hFF);
        rd(0, 0, d); check("R1 irr", d, 8'h00);
        check("R1 int", {7'd0, m_int}, 8'h00);

        // R2 init leaves mask, then mask write
        wr(0, 0, 8'h11); wr(0, 1, 8'h00); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        rd(0, 1, d); check("R2 mask kept", d, 8'hFF);
        wr(0, 1, 8'h00);
        rd(0, 1, d); check("R3 mask load", d, 8'h00);

        // single-level sweep
        for (int l = 0; l < 8; l++) begin
            set_irq(8'h01 << l);
            check("R5 int single", {7'd0, m_int}, 8'h01);
            rd(0, 0, d); check("R4 irr latched", d, 8'h01 << l);
            wr(0, 0, 8'h0C);
            rd(0, 0, d); check("R8 poll level", d, 8'h80 | 8'(l));
            wr(0, 0, 8'h0B);
            rd(0, 0, d); check("R7 isr read", d, 8'h01 << l);
            check("R5 same level blocked", {7'd0, m_int}, 8'h00);
            wr(0, 0, 8'h20);
            rd(0, 0, d); check("R6 eoi clear", d, 8'h00);
            check("R4 no re-request", {7'd0, m_int}, 8'h00);
            wr(0, 0, 8'h0A);
            set_irq(8'h00);
        end

        // pair sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                set_irq((8'h01 << i) | (8'h01 << j));
                wr(0, 0, 8'h0C);
                rd(0, 0, d); check("R5 pair first", d, 8'h80 | 8'(i));
                check("R5 pair nested block", {7'd0, m_int}, 8'h00);
                wr(0, 0, 8'h20);
                check("R6 pair after eoi", {7'd0, m_int}, 8'h01);
                wr(0, 0, 8'h0C);
                rd(0, 0, d); check("R5 pair second", d, 8'h80 | 8'(j));
                wr(0, 0, 8'h20);
                set_irq(8'h00);
            end
        end

        // mask sweep
        for (int m = 0; m < 256; m++) begin
            wr(0, 1, 8'(m));
            set_irq(8'hFF);
            exp = 8'h07;
            for (int b = 7; b >= 0; b--) if (!m[b]) exp = 8'h80 | 8'(b);
            check("R3 int vs mask", {7'd0, m_int}, {7'd0, (m != 255)});
            wr(0, 0, 8'h0C);
            rd(0, 0, d); check("R3 poll vs mask", d, exp);
            wr(0, 0, 8'h20);
            set_irq(8'h00);
        end
        wr(0, 1, 8'h00);

        // R6 nesting
        set_irq(8'h08);
        wr(0, 0, 8'h0C); rd(0, 0, d); check("R8 poll 3", d, 8'h83);
        set_irq(8'h0A);
        check("R5 higher preempts", {7'd0, m_int}, 8'h01);
        wr(0, 0, 8'h0C); rd(0, 0, d); check("R8 poll 1", d, 8'h81);
        wr(0, 0, 8'h0B); rd(0, 0, d); check("R6 nest isr", d, 8'h0A);
        wr(0, 0, 8'h20); rd(0, 0, d); check("R6 lowest cleared", d, 8'h08);
        wr(0, 0, 8'h20); rd(0, 0, d); check("R6 second eoi", d, 8'h00);
        set_irq(8'h00);
        wr(0, 0, 8'h0A);

        // R7 persistence, R4 level drop
        set_irq(8'h40);
        wr(0, 0, 8'h0B);
        rd(0, 0, d); check("R7 isr sel 1", d, 8'h00);
        rd(0, 0, d); check("R7 isr sel 2", d, 8'h00);
        wr(0, 0, 8'h0A);
        rd(0, 0, d); check("R7 irr sel", d, 8'h40);
        set_irq(8'h00);
        rd(0, 0, d); check("R4 drop clears", d, 8'h00);

        // R9 hardware acknowledge
        set_irq(8'h10);
        pulse(); check("R9 no vec on first", {7'd0, p_mvld}, 8'h00);
        pulse(); check("R9 vec valid", {7'd0, p_mvld}, 8'h01);
        check("R9 vec value", p_mvec, 8'h04);
        wr(0, 0, 8'h0B); rd(0, 0, d); check("R9 isr set", d, 8'h10);
        wr(0, 0, 8'h0A); rd(0, 0, d); check("R4 ack clears irr", d, 8'h00);
        wr(0, 0, 8'h20);
        set_irq(8'h00);

        // R10 spurious
        set_irq(8'h40);
        set_irq(8'h00);
        check("R10 int gone", {7'd0, m_int}, 8'h00);
        pulse(); pulse();
        check("R10 vec level 7", p_mvec, 8'h07);
        wr(0, 0, 8'h0B); rd(0, 0, d); check("R10 isr untouched", d, 8'h00);
        wr(0, 0, 8'h0A);
        set_irq(8'h20);
        set_irq(8'h00);
        wr(0, 0, 8'h0C); rd(0, 0, d); check("R10 poll spurious", d, 8'h07);
        wr(0, 0, 8'h0B); rd(0, 0, d); check("R10 poll isr untouched", d, 8'h00);

        // R2 init clears ISR; single mode with relocated base
        set_irq(8'h02);
        wr(0, 0, 8'h0C); rd(0, 0, d); check("R8 poll before init", d, 8'h81);
        wr(0, 0, 8'h13); wr(0, 1, 8'h40); wr(0, 1, 8'h01);
        wr(0, 1, 8'h55);
        rd(0, 1, d); check("R2 single mode mask", d, 8'h55);
        wr(0, 0, 8'h0B); rd(0, 0, d); check("R2 init clears isr", d, 8'h00);
        wr(0, 0, 8'h0A);
        wr(0, 1, 8'h00);
        set_irq(8'h00);
        set_irq(8'h08);
        pulse(); check("R2 no cascade drive", {7'd0, p_casen}, 8'h00);
        pulse(); check("R2 relocated vector", p_mvec, 8'h43);
        wr(0, 0, 8'h20);
        set_irq(8'h00);

        // cascade pair
        init_std(0, 8'h00, 8'h04);
        init_std(1, 8'h08, 8'h02);
        @(negedge clk); s_irq = 8'h20;
        repeat (3) @(posedge clk); #1;
        check("R11 master sees slave", {7'd0, m_int}, 8'h01);
        pulse();
        check("R11 cas enable", {7'd0, p_casen}, 8'h01);
        check("R11 cas level", {5'd0, p_cas}, 8'h02);
        pulse();
        check("R11 master quiet", {7'd0, p_mvld}, 8'h00);
        check("R12 slave drives", {7'd0, p_svld}, 8'h01);
        check("R12 slave vector", p_svec, 8'h0D);
        wr(1, 0, 8'h0B); rd(1, 0, d); check("R12 slave isr", d, 8'h20);
        wr(0, 0, 8'h0B); rd(0, 0, d); check("R11 master isr", d, 8'h04);
        wr(1, 0, 8'h20); wr(0, 0, 8'h20);
        @(negedge clk); s_irq = 8'h00;
        repeat (2) @(posedge clk);

        // R12 slave not selected
        @(negedge clk); s_irq = 8'h20; m_irq = 8'h01;
        repeat (3) @(posedge clk); #1;
        pulse(); check("R12 no cas for level 0", {7'd0, p_casen}, 8'h00);
        pulse();
        check("R12 master vector", p_mvec, 8'h00);
        check("R12 slave silent", {7'd0, p_svld}, 8'h00);
        rd(1, 0, d); check("R12 slave isr untouched", d, 8'h00);
        wr(0, 0, 8'h20);
        @(negedge clk); s_irq = 8'h00; m_irq = 8'h00;
        repeat (2) @(posedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule